// File: doc/BRIEF.md
# Burst-Mode Input/Output Controller

This block is a clocked model of a six-state burst-mode controller. It watches three level inputs (A, B, C) and drives two level outputs (Y, Z). In each state the controller expects one or two input bursts. A burst is a set of input edges that may arrive in any order, with any number of clock cycles between them. The controller fires the burst's grouped output change, and moves to the next state, only after every edge of the burst has landed. An input change that none of the current state's bursts allows sets a sticky protocol-error flag.

The inputs pass through a synchronizer chain of `SYNC_STAGES` flops. The resynchronized levels are compared with the input levels recorded when the current state was entered. The state, the outputs and the error flag are all held in flops, so Y and Z change on a clock edge and never glitch. The state index is brought out for debug.

Top module: `bm_burst_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It leaves the state at index 0, Y=0, Z=1 and the error flag clear, and the input levels expected at that point are ABC=000. Input bit 0 is A, bit 1 is B and bit 2 is C. `state_o` carries the state index in binary.
- R2: In state 0, the burst {A rise, C rise} clears Z and enters state 1. The burst {A rise, B rise} sets Y, clears Z and enters state 2.
- R3: In state 1, C falling sets Z and enters state 3. In state 3, C rising sets Y and enters state 4.
- R4: In state 2, the burst {B fall, C rise} sets Z and enters state 4, so state 4 is always reached with ABC=101 and YZ=11.
- R5: In state 4, A falling clears Y and enters state 5. In state 5, C falling enters state 0 with no output change.
- R6: The edges of a burst are accepted in any order and with any spacing. Outputs and state keep their values until the last edge of the burst has arrived.
- R7: The output change and the state change appear together, on the (SYNC_STAGES+1)-th rising clock edge after the last edge of the burst is applied.
- R8: A partly matched burst never fires. In state 0, A rising alone leaves the state and outputs unchanged for as long as C and B stay still. Completing the burst later still fires it.
- R9: An input change that is compatible with no burst of the current state sets `err_o`, and `err_o` stays set until reset.
- R10: While `err_o` is set, the state and the outputs are frozen, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| abc_i | input | 3 | Asynchronous level inputs: bit 0 A, bit 1 B, bit 2 C |
| y_o | output | 1 | Registered output Y |
| z_o | output | 1 | Registered output Z |
| state_o | output | 3 | Current state index, for debug |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the controller with its default two-stage synchronizer. This puts the commit on the third rising edge after the last burst edge, so the bench can check that exact cycle and the cycle just before it. Bursts are applied with a shuffled edge order and random gaps, along both routes from state 0 to state 4. This lets the per-clock reference model exercise every ordering of the two-edge bursts, including holds on a partial match. Illegal edges are injected both in state 0 and after reaching state 4, so the bench covers the sticky flag and the freeze from more than one state.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int N_IN      = 3;   // bit 0 A, bit 1 B, bit 2 C
    localparam int N_OUT     = 2;   // bit 1 Y, bit 0 Z
    localparam int N_STATE   = 6;
    localparam int MAX_BURST = 2;
    localparam int SW        = $clog2(N_STATE);

    localparam logic [N_IN-1:0]  IN_RESET  = '0;
    localparam logic [N_OUT-1:0] OUT_RESET = 2'b01;

    typedef enum logic [SW-1:0] {
        ST0 = 3'd0,
        ST1 = 3'd1,
        ST2 = 3'd2,
        ST3 = 3'd3,
        ST4 = 3'd4,
        ST5 = 3'd5
    } bm_state_e;

    // One arc of the specification: which inputs it lists, their levels
    // once the burst is done, where it goes, and which outputs it flips.
    typedef struct packed {
        logic             valid;
        logic [N_IN-1:0]  mask;
        logic [N_IN-1:0]  target;
        bm_state_e        next;
        logic [N_OUT-1:0] toggle;
    } burst_t;

    function automatic burst_t mk_burst(input logic [N_IN-1:0] m,
                                        input logic [N_IN-1:0] t,
                                        input bm_state_e n,
                                        input logic [N_OUT-1:0] tg);
        burst_t b;
        b.valid  = 1'b1;
        b.mask   = m;
        b.target = t & m;
        b.next   = n;
        b.toggle = tg;
        return b;
    endfunction

    // Arc table; the index selects among the arcs of one state.
    function automatic burst_t burst_of(input bm_state_e s, input int idx);
        burst_t b;
        b = '0;
        b.next = s;
        case (s)
            ST0: begin
                if (idx == 0)      b = mk_burst(3'b101, 3'b101, ST1, 2'b01);
                else if (idx == 1) b = mk_burst(3'b011, 3'b011, ST2, 2'b11);
            end
            ST1: if (idx == 0) b = mk_burst(3'b100, 3'b000, ST3, 2'b01);
            ST2: if (idx == 0) b = mk_burst(3'b110, 3'b100, ST4, 2'b01);
            ST3: if (idx == 0) b = mk_burst(3'b100, 3'b100, ST4, 2'b10);
            ST4: if (idx == 0) b = mk_burst(3'b001, 3'b000, ST5, 2'b10);
            ST5: if (idx == 0) b = mk_burst(3'b100, 3'b000, ST0, 2'b00);
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bm_burst_match.sv
module bm_burst_match
    import bm_pkg::*;
(
    input  logic [N_IN-1:0] lvl_i,
    input  logic [N_IN-1:0] base_i,
    input  burst_t          burst_i,
    output logic            compat_o,
    output logic            done_o
);

    logic [N_IN-1:0] moved;
    logic            on_target;

    always_comb begin
        moved     = lvl_i ^ base_i;
        // compatible: only inputs this arc lists have moved so far
        compat_o  = burst_i.valid && ((moved & ~burst_i.mask) == '0);
        on_target = ((lvl_i & burst_i.mask) == burst_i.target);
        done_o    = compat_o && on_target && (burst_i.mask != '0);
    end

endmodule

// File: rtl/bm_commit.sv
module bm_commit
    import bm_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [N_IN-1:0]      lvl_i,
    input  logic [MAX_BURST-1:0] compat_i,
    input  logic [MAX_BURST-1:0] done_i,
    input  burst_t               tbl_i [MAX_BURST],
    output bm_state_e            state_o,
    output logic [N_OUT-1:0]     out_o,
    output logic [N_IN-1:0]      base_o,
    output logic                 err_o
);

    bm_state_e        state_q, nxt_state;
    logic [N_OUT-1:0] out_q, nxt_tog;
    logic [N_IN-1:0]  base_q;
    logic             err_q, fire, illegal;

    always_comb begin
        fire      = 1'b0;
        nxt_state = state_q;
        nxt_tog   = '0;
        for (int g = 0; g < MAX_BURST; g++) begin
            if (done_i[g] && !fire) begin
                fire      = 1'b1;
                nxt_state = tbl_i[g].next;
                nxt_tog   = tbl_i[g].toggle;
            end
        end
        illegal = ((lvl_i ^ base_q) != '0) && (compat_i == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST0;
            out_q   <= OUT_RESET;
            base_q  <= IN_RESET;
            err_q   <= 1'b0;
        end else if (!err_q) begin
            if (illegal) begin
                err_q <= 1'b1;
            end else if (fire) begin
                state_q <= nxt_state;
                out_q   <= out_q ^ nxt_tog;
                base_q  <= lvl_i;
            end
        end
    end

    assign state_o = state_q;
    assign out_o   = out_q;
    assign base_o  = base_q;
    assign err_o   = err_q;

    // R1
    reset_values_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_q == ST0 && out_q == OUT_RESET && !err_q));

    // R2
    st0_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == ST0 |=> (state_q == ST0 || state_q == ST1 || state_q == ST2));

    // R5
    st5_quiet_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == ST5 |=> (state_q == ST5 || (state_q == ST0 && $stable(out_q))));

    // R7
    out_with_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(out_q) |-> !$stable(state_q));

    // R8
    single_fire_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(done_i));

    // R9
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        err_q |=> err_q);

    // R10
    err_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        err_q |=> ($stable(state_q) && $stable(out_q)));

endmodule

// File: rtl/bm_burst_ctrl.sv
module bm_burst_ctrl
    import bm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [2:0]    abc_i,
    output logic          y_o,
    output logic          z_o,
    output logic [SW-1:0] state_o,
    output logic          err_o
);

    logic [N_IN-1:0]      lvl, base;
    logic [MAX_BURST-1:0] compat, done;
    logic [N_OUT-1:0]     outs;
    bm_state_e            state;
    burst_t               tbl [MAX_BURST];

    bm_sync #(
        .WIDTH  (N_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_RESET)
    ) u_sync (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (abc_i),
        .q_o  (lvl)
    );

    for (genvar g = 0; g < MAX_BURST; g++) begin : g_match
        assign tbl[g] = burst_of(state, g);
        bm_burst_match u_match (
            .lvl_i   (lvl),
            .base_i  (base),
            .burst_i (tbl[g]),
            .compat_o(compat[g]),
            .done_o  (done[g])
        );
    end

    bm_commit u_commit (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .lvl_i   (lvl),
        .compat_i(compat),
        .done_i  (done),
        .tbl_i   (tbl),
        .state_o (state),
        .out_o   (outs),
        .base_o  (base),
        .err_o   (err_o)
    );

    assign y_o     = outs[1];
    assign z_o     = outs[0];
    assign state_o = state;

endmodule

// File: tb/bm_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module bm_burst_ctrl_tb_top;

    localparam int SYNC     = 2;
    localparam int WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] abc = 3'b000;
    logic       y, z, err;
    logic [2:0] state;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 4 ns period

    bm_burst_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .abc_i  (abc),
        .y_o    (y),
        .z_o    (z),
        .state_o(state),
        .err_o  (err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (integers, A=1 B=2 C=4, Y=2 Z=1)
    int m_st, m_yz, m_base, m_err;
    int m_pipe [SYNC];

    function automatic void spec_arc(input int st, input int k, output int v,
                                     output int msk, output int tgt,
                                     output int nx, output int tg);
        v = 1; msk = 0; tgt = 0; nx = st; tg = 0;
        case (st * 2 + k)
            0:  begin msk = 5; tgt = 5; nx = 1; tg = 1; end
            1:  begin msk = 3; tgt = 3; nx = 2; tg = 3; end
            2:  begin msk = 4; tgt = 0; nx = 3; tg = 1; end
            4:  begin msk = 6; tgt = 4; nx = 4; tg = 1; end
            6:  begin msk = 4; tgt = 4; nx = 4; tg = 2; end
            8:  begin msk = 1; tgt = 0; nx = 5; tg = 2; end
            10: begin msk = 4; tgt = 0; nx = 0; tg = 0; end
            default: v = 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_yz = 1; m_base = 0; m_err = 0;
            for (int i = 0; i < SYNC; i++) m_pipe[i] = 0;
        end else begin
            int lvl, moved, anyc, fired, nst, ntg;
            int v, msk, tgt, nx, tg;
            lvl = m_pipe[SYNC-1];
            if (m_err == 0) begin
                moved = lvl ^ m_base;
                anyc = 0; fired = 0; nst = m_st; ntg = 0;
                for (int k = 0; k < 2; k++) begin
                    spec_arc(m_st, k, v, msk, tgt, nx, tg);
                    if (v != 0 && (moved & ~msk & 7) == 0) begin
                        anyc = 1;
                        if (fired == 0 && (lvl & msk) == tgt) begin
                            fired = 1; nst = nx; ntg = tg;
                        end
                    end
                end
                if (moved != 0 && anyc == 0) m_err = 1;
                else if (fired != 0) begin
                    m_st = nst; m_yz = m_yz ^ ntg; m_base = lvl;
                end
            end
            for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = int'(abc);
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6", "model state", int'(state), m_st);
            check("R7", "model YZ", int'({y, z}), m_yz);
            check("R9", "model err", int'(err), m_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual %0d expected %0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply the edges listed in msk in shuffled order with random gaps,
    // then check the exact commit cycle.
    task automatic apply_burst(input int msk, input int exp_st, input int exp_yz, input string req);
        int idx [3];
        int n, pre_st, pre_yz;
        n = 0;
        for (int b = 0; b < 3; b++) if (msk[b]) begin idx[n] = b; n++; end
        for (int i = n - 1; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = idx[i]; idx[i] = idx[j]; idx[j] = t;
        end
        pre_st = int'(state); pre_yz = int'({y, z});
        for (int i = 0; i < n; i++) begin
            if (i == n - 1) begin
                check("R6", "held state before last edge", int'(state), pre_st);
                check("R6", "held YZ before last edge", int'({y, z}), pre_yz);
            end
            abc[idx[i]] = ~abc[idx[i]];
            if (i != n - 1) wait_cyc($urandom_range(3, 1));
        end
        wait_cyc(SYNC);
        check("R7", "state one edge before commit", int'(state), pre_st);
        wait_cyc(1);
        check(req, "state after burst", int'(state), exp_st);
        check(req, "YZ after burst", int'({y, z}), exp_yz);
        wait_cyc($urandom_range(3, 0));
    endtask

    task automatic do_reset();
        rst = 1; abc = 3'b000;
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        check("R1", "reset state", int'(state), 0);
        check("R1", "reset YZ", int'({y, z}), 1);
        check("R1", "reset err", int'(err), 0);
    endtask

    task automatic round_trip(input bit via_s1);
        if (via_s1) begin
            apply_burst(5, 1, 0, "R2");
            apply_burst(4, 3, 1, "R3");
            apply_burst(4, 4, 3, "R3");
        end else begin
            apply_burst(3, 2, 2, "R2");
            apply_burst(6, 4, 3, "R4");
        end
        check("R4", "inputs at state 4", int'(abc), 5);
        apply_burst(1, 5, 1, "R5");
        apply_burst(4, 0, 1, "R5");
    endtask

    initial begin
        wait_cyc(1);
        do_reset();

        for (int it = 0; it < 6; it++) round_trip(it[0]);

        // R8: partial match holds, then completes
        abc[0] = 1'b1;
        wait_cyc(12);
        check("R8", "state on partial burst", int'(state), 0);
        check("R8", "YZ on partial burst", int'({y, z}), 1);
        check("R8", "no error on partial burst", int'(err), 0);
        abc[2] = 1'b1;
        wait_cyc(SYNC + 1);
        check("R8", "state after completion", int'(state), 1);
        check("R8", "YZ after completion", int'({y, z}), 0);
        apply_burst(4, 3, 1, "R3");
        apply_burst(4, 4, 3, "R3");
        apply_burst(1, 5, 1, "R5");
        apply_burst(4, 0, 1, "R5");

        // R9: B and C together in state 0 match no arc
        abc[1] = 1'b1;
        wait_cyc(1);
        abc[2] = 1'b1;
        wait_cyc(SYNC + 2);
        check("R9", "err after illegal change", int'(err), 1);
        check("R9", "state at error", int'(state), 0);
        // R10: inputs keep moving, nothing changes
        abc = 3'b101;
        wait_cyc(6);
        abc = 3'b000;
        wait_cyc(6);
        check("R10", "frozen state", int'(state), 0);
        check("R10", "frozen YZ", int'({y, z}), 1);
        check("R9", "err still set", int'(err), 1);

        do_reset();

        // illegal B edge in state 4
        apply_burst(3, 2, 2, "R2");
        apply_burst(6, 4, 3, "R4");
        abc[1] = 1'b1;
        wait_cyc(SYNC + 2);
        check("R9", "err in state 4", int'(err), 1);
        abc[0] = 1'b0;
        wait_cyc(SYNC + 3);
        check("R10", "state 4 frozen", int'(state), 4);
        check("R10", "YZ frozen at 11", int'({y, z}), 3);

        do_reset();
        round_trip(1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule